// File: doc/BRIEF.md
# Double-Buffered PWM Duty Comparator

This block holds the duty-cycle settings for a group of PWM channels and turns a shared time-base count into one raw, active-high PWM level per channel. Each channel has two 16-bit registers. Software writes only the staging register. The comparator reads only the live register, which takes the staged value at one point of the period. A new duty value therefore never cuts a pulse short or doubles it.

The time base is outside the block. The block receives the count, the period, the count direction, an enable and a mode select. The mode sets when staged values go live:
- edge-aligned: at the end of the period;
- centre-aligned up/down: at the bottom of the count;
- up/down with double updates: at the bottom and at the top.

An update-inhibit input freezes the live registers in edge-aligned mode. Bits 15:1 of the duty word are compared against the 15-bit count. Bit 0 adds half-count resolution: a clock-phase-delayed edge either lengthens or delays the pulse by half a count.

Top module: `pwm_duty_cmp`

## Requirements
- R1: While reset is asserted and after it is released, every live duty register reads 0 and every PWM output is low, until the first transfer.
- R2: A write to a staging register does not change the live register in the middle of an enabled edge-aligned period. Here mode_i = 2'b00, and mid-period means any count other than the period value.
- R3: In edge-aligned mode with the time base enabled, the staged value goes live on the clock edge that registers the count equal to the period. The new value governs the output from the following count 0.
- R4: In edge-aligned mode, upd_dis_i = 1 blocks every transfer. This holds whether the time base is enabled or disabled.
- R5: In up/down mode (mode_i = 2'b01), the transfer happens only at count 0 while counting up (tb_down_i = 0). It does not happen when the count equals the period.
- R6: In double-update mode (mode_i = 2'b10 or 2'b11), transfers happen both at count 0 counting up and at the count equal to the period.
- R7: While the time base is disabled, the live register takes the staging register's value on every clock edge. In edge-aligned mode this also requires upd_dis_i = 0. A value written in one cycle is therefore live two edges after it was presented.
- R8: Each PWM output is high for a count c when c is below bits 15:1 of the live duty value. The output appears one clock after the count is presented.
- R9: When bit 0 of the live duty value is 1, counting up (tb_down_i = 0) and c equals bits 15:1, the output is high for the first half of that clock cycle and low for the second half.
- R10: Under the same condition while counting down (tb_down_i = 1), the output is low for the first half of that clock cycle and high for the second half.
- R11: upd_dis_i has no effect in either up/down mode.
- R12: Channels are independent. wr_sel_i picks the channel whose staging register is written. Bits [16*k+15:16*k] of duty_active_o and bit k of pwm_o belong to channel k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the time base advances at most one count per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| tb_cnt_i | input | 15 | Time-base count |
| tb_period_i | input | 15 | Time-base period value |
| tb_down_i | input | 1 | Count direction, 1 = counting down |
| tb_en_i | input | 1 | Time-base enable |
| mode_i | input | 2 | 00 edge-aligned, 01 up/down, 1x up/down with double updates |
| upd_dis_i | input | 1 | Inhibits transfers in edge-aligned mode |
| wr_en_i | input | 1 | Staging register write strobe |
| wr_sel_i | input | 2 | Channel picked for the write |
| wr_data_i | input | 16 | Duty value to stage |
| pwm_o | output | 3 | Raw active-high PWM level per channel |
| duty_active_o | output | 48 | Live duty registers, channel k at bits 16k+15:16k |

## Verification
Several properties are checked at every clock edge:
- the live registers hold still wherever a transfer is forbidden: mid-period in edge-aligned mode, under the update inhibit, and away from the upward zero in up/down mode;
- a count below the live threshold always gives a high output;
- a zero duty value always gives a low output;
- the half-step case ends its cycle at the level the direction calls for.

Only the bench scenarios can show the rest:
- that transfers really happen at the period, at the upward zero and while the time base is disabled, and that they carry the right value;
- the first-half level of the half-step;
- that writes reach only the selected channel.

// File: rtl/pwm_duty_cmp_pkg.sv
package pwm_duty_cmp_pkg;

   typedef enum logic [1:0] {
      PWMDC_EDGE     = 2'b00,
      PWMDC_CENTER   = 2'b01,
      PWMDC_CTR_DBL  = 2'b10,
      PWMDC_CTR_DBL2 = 2'b11
   } pwmdc_mode_e;

endpackage

// File: rtl/pwmdc_xfer_ctrl.sv
// Decides, per clock, whether staged duty values move into the live registers.
module pwmdc_xfer_ctrl
   import pwm_duty_cmp_pkg::*;
#(
   parameter int CNT_W = 15
) (
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [CNT_W-1:0] period_i,
   input  logic             down_i,
   input  logic             en_i,
   input  logic [1:0]       mode_i,
   input  logic             upd_dis_i,
   output logic             load_o
);

   logic at_top;
   logic at_bottom_up;

   assign at_top       = (cnt_i == period_i);
   assign at_bottom_up = (cnt_i == '0) && !down_i;

   always_comb begin
      load_o = 1'b0;
      if (mode_i == PWMDC_EDGE) begin
         // update inhibit gates both the running and the idle transfer
         load_o = !upd_dis_i && (!en_i || at_top);
      end else if (mode_i == PWMDC_CENTER) begin
         load_o = !en_i || at_bottom_up;
      end else begin
         load_o = !en_i || at_bottom_up || at_top;
      end
   end

endmodule

// File: rtl/pwmdc_half_phase.sv
// Tells which half of the current clock cycle is running, using one flop per edge.
module pwmdc_half_phase (
   input  logic clk,
   input  logic rst_n,
   output logic second_half_o
);

   logic tgl_pos;
   logic tgl_neg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tgl_pos <= 1'b0;
      else        tgl_pos <= !tgl_pos;
   end

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) tgl_neg <= 1'b0;
      else        tgl_neg <= tgl_pos;
   end

   // the two toggles differ from a rising edge until the next falling edge
   assign second_half_o = (tgl_pos == tgl_neg);

endmodule

// File: rtl/pwmdc_channel.sv
// One channel: staging register, live register, comparator and half-step edge.
module pwmdc_channel #(
   parameter int DUTY_W = 16,
   localparam int CNT_W = DUTY_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [DUTY_W-1:0] wr_data_i,
   input  logic              load_i,
   input  logic [CNT_W-1:0]  cnt_i,
   input  logic              down_i,
   input  logic              second_half_i,
   output logic [DUTY_W-1:0] act_o,
   output logic              pwm_o
);

   logic [DUTY_W-1:0] stage_q;
   logic [DUTY_W-1:0] act_q;
   logic [CNT_W-1:0]  thresh;
   logic              below_q;
   logic              half_q;
   logic              down_q;

   assign thresh = act_q[DUTY_W-1:1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '0;
         act_q   <= '0;
      end else begin
         if (wr_en_i) stage_q <= wr_data_i;
         if (load_i)  act_q   <= stage_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         below_q <= 1'b0;
         half_q  <= 1'b0;
         down_q  <= 1'b0;
      end else begin
         below_q <= (cnt_i < thresh);
         half_q  <= act_q[0] && (cnt_i == thresh);
         down_q  <= down_i;
      end
   end

   assign act_o = act_q;
   assign pwm_o = below_q | (half_q & (down_q ? second_half_i : !second_half_i));

   a_r8_below_is_high: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_i < act_q[DUTY_W-1:1]) |=> pwm_o);

   a_r8_zero_is_low: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q == '0) |=> !pwm_o);

   a_r9_up_half_ends_low: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q[0] && cnt_i == act_q[DUTY_W-1:1] && !down_i) |=> !pwm_o);

   a_r10_down_half_ends_high: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q[0] && cnt_i == act_q[DUTY_W-1:1] && down_i) |=> pwm_o);

endmodule

// File: rtl/pwm_duty_cmp.sv
module pwm_duty_cmp
   import pwm_duty_cmp_pkg::*;
#(
   parameter int NUM_CH = 3,
   parameter int DUTY_W = 16,
   localparam int CNT_W = DUTY_W - 1,
   localparam int SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [CNT_W-1:0]         tb_cnt_i,
   input  logic [CNT_W-1:0]         tb_period_i,
   input  logic                     tb_down_i,
   input  logic                     tb_en_i,
   input  logic [1:0]               mode_i,
   input  logic                     upd_dis_i,
   input  logic                     wr_en_i,
   input  logic [SEL_W-1:0]         wr_sel_i,
   input  logic [DUTY_W-1:0]        wr_data_i,
   output logic [NUM_CH-1:0]        pwm_o,
   output logic [NUM_CH*DUTY_W-1:0] duty_active_o
);

   initial begin
      a_cfg_duty_w: assert (DUTY_W >= 2)
         else $error("DUTY_W must leave at least one compare bit");
      a_cfg_num_ch: assert (NUM_CH >= 1)
         else $error("NUM_CH must be at least 1");
   end

   logic load;
   logic second_half;

   pwmdc_xfer_ctrl #(.CNT_W(CNT_W)) u_xfer (
      .cnt_i     (tb_cnt_i),
      .period_i  (tb_period_i),
      .down_i    (tb_down_i),
      .en_i      (tb_en_i),
      .mode_i    (mode_i),
      .upd_dis_i (upd_dis_i),
      .load_o    (load)
   );

   pwmdc_half_phase u_phase (
      .clk           (clk),
      .rst_n         (rst_n),
      .second_half_o (second_half)
   );

   for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
      logic wr_hit;
      assign wr_hit = wr_en_i && (wr_sel_i == SEL_W'(k));

      pwmdc_channel #(.DUTY_W(DUTY_W)) u_chan (
         .clk           (clk),
         .rst_n         (rst_n),
         .wr_en_i       (wr_hit),
         .wr_data_i     (wr_data_i),
         .load_i        (load),
         .cnt_i         (tb_cnt_i),
         .down_i        (tb_down_i),
         .second_half_i (second_half),
         .act_o         (duty_active_o[k*DUTY_W +: DUTY_W]),
         .pwm_o         (pwm_o[k])
      );

      a_r2_edge_hold_midperiod: assert property (@(posedge clk) disable iff (!rst_n)
         (tb_en_i && mode_i == PWMDC_EDGE && tb_cnt_i != tb_period_i)
         |=> $stable(duty_active_o[k*DUTY_W +: DUTY_W]));

      a_r4_inhibit_freezes: assert property (@(posedge clk) disable iff (!rst_n)
         (mode_i == PWMDC_EDGE && upd_dis_i)
         |=> $stable(duty_active_o[k*DUTY_W +: DUTY_W]));

      a_r5_center_only_at_zero_up: assert property (@(posedge clk) disable iff (!rst_n)
         (tb_en_i && mode_i == PWMDC_CENTER && !(tb_cnt_i == '0 && !tb_down_i))
         |=> $stable(duty_active_o[k*DUTY_W +: DUTY_W]));
   end

endmodule

// File: tb/pwm_duty_cmp_tb.sv
module pwm_duty_cmp_tb;

   localparam int NCH = 3;
   localparam int DW  = 16;
   localparam int CW  = DW - 1;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [CW-1:0]    tb_cnt = '0;
   logic [CW-1:0]    tb_period = '0;
   logic             tb_down = 1'b0;
   logic             tb_en = 1'b0;
   logic [1:0]       mode = 2'b00;
   logic             upd_dis = 1'b0;
   logic             wr_en = 1'b0;
   logic [1:0]       wr_sel = '0;
   logic [DW-1:0]    wr_data = '0;
   logic [NCH-1:0]   pwm;
   logic [NCH*DW-1:0] duty_act;

   int n_chk = 0;
   int n_err = 0;

   logic           pend_wr = 1'b0;
   logic [1:0]     pend_sel = '0;
   logic [DW-1:0]  pend_data = '0;
   logic [NCH-1:0] obs_f;
   logic [NCH-1:0] obs_s;
   logic [NCH*DW-1:0] obs_act;

   always #4 clk = !clk;

   pwm_duty_cmp #(.NUM_CH(NCH), .DUTY_W(DW)) u_dut (
      .clk(clk), .rst_n(rst_n), .tb_cnt_i(tb_cnt), .tb_period_i(tb_period),
      .tb_down_i(tb_down), .tb_en_i(tb_en), .mode_i(mode), .upd_dis_i(upd_dis),
      .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
      .pwm_o(pwm), .duty_active_o(duty_act)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] act_of(input int ch);
      return obs_act[ch*DW +: DW];
   endfunction

   // Drive a count after the edge; samples then belong to the previous count.
   task automatic step(input int c, input logic d);
      @(posedge clk);
      #1;
      tb_cnt  = CW'(c);
      tb_down = d;
      wr_en   = pend_wr;
      wr_sel  = pend_sel;
      wr_data = pend_data;
      pend_wr = 1'b0;
      #1;
      obs_f   = pwm;
      obs_act = duty_act;
      #4;
      obs_s   = pwm;
   endtask

   task automatic queue_wr(input int ch, input logic [DW-1:0] v);
      pend_wr   = 1'b1;
      pend_sel  = 2'(ch);
      pend_data = v;
   endtask

   task automatic chk_level(input string req, input int ch, input int c, input logic d,
                            input int th, input logic lsb);
      logic ef, es;
      ef = (c < th) || (c == th && lsb && !d);
      es = (c < th) || (c == th && lsb && d);
      chk({req, " first half"},  32'(obs_f[ch]), 32'(ef));
      chk({req, " second half"}, 32'(obs_s[ch]), 32'(es));
   endtask

   task automatic run_edge_period(input int p, input int ch, input int th,
                                  input logic lsb, input string req);
      for (int c = 0; c <= p; c++) begin
         step(c, 1'b0);
         if (c > 0) chk_level(req, ch, c - 1, 1'b0, th, lsb);
      end
      step(0, 1'b0);
      chk_level(req, ch, p, 1'b0, th, lsb);
   endtask

   task automatic run_updown(input int p, input int ch, input int th,
                             input logic lsb, input string req);
      int pc;
      logic pd;
      pc = 0; pd = 1'b0;
      for (int c = 0; c <= p; c++) begin
         step(c, 1'b0);
         if (c > 0) chk_level(req, ch, pc, pd, th, lsb);
         pc = c; pd = 1'b0;
      end
      for (int c = p - 1; c >= 1; c--) begin
         step(c, 1'b1);
         chk_level(req, ch, pc, pd, th, lsb);
         pc = c; pd = 1'b1;
      end
      step(0, 1'b0);
      chk_level(req, ch, pc, pd, th, lsb);
   endtask

   task automatic t_reset;
      #3;
      chk("R1 pwm in reset", 32'(pwm), 32'h0);
      chk("R1 live regs in reset", 32'(duty_act[31:0]), 32'h0);
      @(posedge clk); #1 rst_n = 1'b1;
      step(0, 1'b0);
      step(0, 1'b0);
      chk("R1 pwm after reset", 32'(obs_s), 32'h0);
      chk("R1 live ch0 after reset", 32'(act_of(0)), 32'h0);
   endtask

   task automatic t_idle_load;
      queue_wr(0, 16'h0014);
      step(0, 1'b0);
      step(0, 1'b0);
      chk("R7 not yet live", 32'(act_of(0)), 32'h0);
      step(0, 1'b0);
      chk("R7 live two edges after write", 32'(act_of(0)), 32'h0014);
   endtask

   task automatic t_edge_basic;
      tb_period = CW'(19);
      tb_en = 1'b1;
      run_edge_period(19, 0, 10, 1'b0, "R8 edge compare");
   endtask

   task automatic t_edge_xfer;
      for (int c = 0; c <= 3; c++) step(c, 1'b0);
      queue_wr(0, 16'h0028);
      for (int c = 4; c <= 19; c++) step(c, 1'b0);
      chk("R2 no mid-period transfer", 32'(act_of(0)), 32'h0014);
      step(0, 1'b0);
      chk("R3 transfer at period", 32'(act_of(0)), 32'h0028);
      chk("R3 old value at period count", 32'(obs_f[0]), 32'h0);
      run_edge_period(19, 0, 20, 1'b0, "R3 new value from zero");
   endtask

   task automatic t_inhibit;
      upd_dis = 1'b1;
      queue_wr(0, 16'h0008);
      run_edge_period(19, 0, 20, 1'b0, "R4 inhibited compare");
      step(1, 1'b0);
      chk("R4 inhibited while running", 32'(act_of(0)), 32'h0028);
      tb_en = 1'b0;
      for (int i = 0; i < 3; i++) step(1, 1'b0);
      chk("R4 inhibited while idle", 32'(act_of(0)), 32'h0028);
      upd_dis = 1'b0;
      step(1, 1'b0);
      step(1, 1'b0);
      chk("R7 idle load after inhibit release", 32'(act_of(0)), 32'h0008);
   endtask

   task automatic t_half_up;
      queue_wr(0, 16'h0015);
      for (int i = 0; i < 3; i++) step(0, 1'b0);
      chk("R7 half-step value loaded", 32'(act_of(0)), 32'h0015);
      tb_en = 1'b1;
      run_edge_period(19, 0, 10, 1'b1, "R9 half-step up");
   endtask

   task automatic t_center;
      tb_en = 1'b0;
      mode = 2'b01;
      tb_period = CW'(12);
      queue_wr(0, 16'h000B);
      for (int i = 0; i < 3; i++) step(0, 1'b0);
      chk("R7 up/down idle load", 32'(act_of(0)), 32'h000B);
      tb_en = 1'b1;
      run_updown(12, 0, 5, 1'b1, "R10 half-step up/down");
      queue_wr(0, 16'h0004);
      for (int c = 1; c <= 12; c++) step(c, 1'b0);
      step(11, 1'b1);
      chk("R5 no transfer at top", 32'(act_of(0)), 32'h000B);
      for (int c = 10; c >= 1; c--) step(c, 1'b1);
      step(0, 1'b0);
      step(1, 1'b0);
      chk("R5 transfer at zero going up", 32'(act_of(0)), 32'h0004);
   endtask

   task automatic t_double;
      mode = 2'b10;
      upd_dis = 1'b1;
      queue_wr(0, 16'h0009);
      for (int c = 2; c <= 12; c++) step(c, 1'b0);
      step(11, 1'b1);
      chk("R6 transfer at top", 32'(act_of(0)), 32'h0009);
      chk("R11 inhibit ignored at top", 32'(act_of(0) == 16'h0009), 32'h1);
      queue_wr(0, 16'h0006);
      for (int c = 10; c >= 1; c--) step(c, 1'b1);
      step(0, 1'b0);
      step(1, 1'b0);
      chk("R6 transfer at zero", 32'(act_of(0)), 32'h0006);
      run_updown(12, 0, 3, 1'b0, "R6 R11 compare after double update");
      upd_dis = 1'b0;
   endtask

   task automatic t_channels;
      tb_en = 1'b0;
      mode = 2'b00;
      tb_period = CW'(19);
      queue_wr(1, 16'hFFFF);
      step(0, 1'b0);
      queue_wr(2, 16'h0000);
      step(0, 1'b0);
      step(0, 1'b0);
      step(0, 1'b0);
      chk("R12 ch1 live", 32'(act_of(1)), 32'hFFFF);
      chk("R12 ch2 live", 32'(act_of(2)), 32'h0);
      chk("R12 ch0 untouched", 32'(act_of(0)), 32'h0006);
      tb_en = 1'b1;
      run_edge_period(19, 1, 32'h7FFF, 1'b1, "R12 ch1 always high");
      run_edge_period(19, 2, 0, 1'b0, "R12 ch2 always low");
   endtask

   initial begin
      t_reset();
      t_idle_load();
      t_edge_basic();
      t_edge_xfer();
      t_inhibit();
      t_half_up();
      t_center();
      t_double();
      t_channels();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule